// File: doc/BRIEF.md
# Programmable March Test Sequencer

This block is a built-in self-test sequencer for a synchronous single-port RAM of 2^ADDR_W words, each DATA_W bits wide. After a start request it works through one of several March algorithms. Each algorithm is held as a short list of elements. An element has an address direction, an optional data-retention pause in front of it, and a list of up to three read or write operations. Every write puts a solid background into the word, either all zeros or all ones. Every read is checked against the background the algorithm expects at that point.

The RAM is expected to return read data one cycle after the read strobe. The engine compares that data in the following cycle. On the first mismatch it records the address, the element index and the word that came back. The run does not stop on a mismatch, so the elapsed time of a test depends only on the algorithm, the memory size and the pause length. The pause length comes from an input that gives the number of clock cycles to wait. The CNT_W parameter sets the width of that input, so a pause of about 100 ms can be reached at the system clock rate.

Top module: `mbist_march_engine`

## Requirements
- R1: While reset is held and after it is released, busy, done and fail are 0, and neither mem_we nor mem_re is asserted.
- R2: A start high at a rising edge while busy is 0 begins a run. busy is 1 from that edge on. A start high while busy is 1 has no effect on the sequence or the result.
- R3: Exactly one operation is issued per cycle. All operations of an element are applied to one address before the address moves. An ascending element visits addresses 0 up to 2^ADDR_W-1, and a descending element visits 2^ADDR_W-1 down to 0. The first operation appears in the cycle right after the start edge. mem_we and mem_re are never both high.
- R4: alg_sel picks the element list. Up is ascending and down is descending.
  - 0: w0 up; r0 w1 up; r1 up.
  - 1: w0 up; r0 w1 up; r1 w0 down.
  - 2: w0 up; r0 w1 up; r1 w0 r0 down.
  - 3: w0 up; r0 w1 up; r1 w0 down; r0 up.
  - 4: w0 up; r0 w1 up; r1 w0 up; r0 w1 down; r1 w0 down; r0 up.
  - 5: w0 up; r0 w1 r1 up; r1 w0 r0 down; r0 up.
  - 6: w0 up; r0 w1 up; r1 w0 up; r0 w1 down; r1 w0 down; pause then r0 w1 up; pause then r1 up.
  - 7: runs the same list as code 1.
  - Elements are numbered from 0.
- R5: A write of value b drives mem_wdata with b in every bit.
- R6: Read data is compared in the cycle after the read strobe with the expected value in every bit. The first mismatch of a run sets fail and captures fail_addr, fail_elem (element index) and fail_data (the word read). Later mismatches in the same run change none of these.
- R7: A run lasts exactly (operations + pause cycles + 1) cycles with busy high, where the final cycle issues no operation. done then rises as busy falls. done and the fail outputs hold until the next accepted start, which clears them.
- R8: Each pause inserts ret_cycles+1 cycles with busy high and no memory access. ret_cycles is sampled at the accepted start.
- R9: On a memory that returns what was written, fail stays 0 for every algorithm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Run request, sampled while idle |
| alg_sel | input | 3 | Algorithm code (R4) |
| ret_cycles | input | CNT_W | Retention pause length minus one, in cycles |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run finished |
| fail | output | 1 | A mismatch was seen in the last run |
| fail_addr | output | ADDR_W | Address of the first mismatch |
| fail_elem | output | 3 | Element index of the first mismatch |
| fail_data | output | DATA_W | Word read at the first mismatch |
| mem_addr | output | ADDR_W | RAM address |
| mem_we | output | 1 | RAM write strobe |
| mem_re | output | 1 | RAM read strobe |
| mem_wdata | output | DATA_W | RAM write data |
| mem_rdata | input | DATA_W | RAM read data, one cycle after mem_re |

## Verification
The compare of the last read of a run lands in the drain cycle. A mismatch there is latched on the same edge that raises done and drops busy. The bench provokes this with a stuck bit at the final address visited by the last element of the shortest algorithm. It then judges that done, fail and the captured address, element and data are all correct together on the first idle cycle. Random runs add stuck-bit faults at random positions, and sometimes pulse start in the middle of a run. Each issued operation is compared against a sequence that the bench derives itself.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

   typedef enum logic [2:0] {
      ALG_MATS   = 3'd0,
      ALG_MATSP  = 3'd1,
      ALG_MATSPP = 3'd2,
      ALG_MX     = 3'd3,
      ALG_MCM    = 3'd4,
      ALG_MY     = 3'd5,
      ALG_IFA9   = 3'd6,
      ALG_RSVD   = 3'd7
   } alg_e;

   // op i of an element: rd[i]=1 read, val[i] the background bit
   typedef struct packed {
      logic       down;
      logic       pause;
      logic [1:0] nops;
      logic [2:0] rd;
      logic [2:0] val;
   } elem_t;

   localparam int ELEM_IDX_W = 3;

   function automatic elem_t mk_el(input logic dn, input logic ps, input logic [1:0] n,
                                   input logic [2:0] r, input logic [2:0] v);
      elem_t e;
      e.down = dn;
      e.pause = ps;
      e.nops = n;
      e.rd = r;
      e.val = v;
      return e;
   endfunction

   function automatic elem_t alg_elem(input logic [2:0] alg, input logic [2:0] idx);
      elem_t w0, u_r0w1, u_r1w0, d_r0w1, d_r1w0, u_r0, u_r1;
      elem_t e;
      w0     = mk_el(1'b0, 1'b0, 2'd1, 3'b000, 3'b000);
      u_r0w1 = mk_el(1'b0, 1'b0, 2'd2, 3'b001, 3'b010);
      u_r1w0 = mk_el(1'b0, 1'b0, 2'd2, 3'b001, 3'b001);
      d_r0w1 = mk_el(1'b1, 1'b0, 2'd2, 3'b001, 3'b010);
      d_r1w0 = mk_el(1'b1, 1'b0, 2'd2, 3'b001, 3'b001);
      u_r0   = mk_el(1'b0, 1'b0, 2'd1, 3'b001, 3'b000);
      u_r1   = mk_el(1'b0, 1'b0, 2'd1, 3'b001, 3'b001);
      e = w0;
      case (alg)
         ALG_MATS: case (idx)
            3'd1: e = u_r0w1;
            3'd2: e = u_r1;
            default: e = w0;
         endcase
         ALG_MATSPP: case (idx)
            3'd1: e = u_r0w1;
            3'd2: e = mk_el(1'b1, 1'b0, 2'd3, 3'b101, 3'b001);
            default: e = w0;
         endcase
         ALG_MX: case (idx)
            3'd1: e = u_r0w1;
            3'd2: e = d_r1w0;
            3'd3: e = u_r0;
            default: e = w0;
         endcase
         ALG_MCM: case (idx)
            3'd1: e = u_r0w1;
            3'd2: e = u_r1w0;
            3'd3: e = d_r0w1;
            3'd4: e = d_r1w0;
            3'd5: e = u_r0;
            default: e = w0;
         endcase
         ALG_MY: case (idx)
            3'd1: e = mk_el(1'b0, 1'b0, 2'd3, 3'b101, 3'b110);
            3'd2: e = mk_el(1'b1, 1'b0, 2'd3, 3'b101, 3'b001);
            3'd3: e = u_r0;
            default: e = w0;
         endcase
         ALG_IFA9: case (idx)
            3'd1: e = u_r0w1;
            3'd2: e = u_r1w0;
            3'd3: e = d_r0w1;
            3'd4: e = d_r1w0;
            3'd5: e = mk_el(1'b0, 1'b1, 2'd2, 3'b001, 3'b010);
            3'd6: e = mk_el(1'b0, 1'b1, 2'd1, 3'b001, 3'b001);
            default: e = w0;
         endcase
         default: case (idx)
            3'd1: e = u_r0w1;
            3'd2: e = d_r1w0;
            default: e = w0;
         endcase
      endcase
      return e;
   endfunction

   function automatic logic [2:0] alg_last(input logic [2:0] alg);
      case (alg)
         ALG_MX:   return 3'd3;
         ALG_MCM:  return 3'd5;
         ALG_MY:   return 3'd3;
         ALG_IFA9: return 3'd6;
         default:  return 3'd2;
      endcase
   endfunction

endpackage

// File: rtl/mbist_seq.sv
module mbist_seq
   import mbist_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int CNT_W  = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic [2:0]            alg,
   input  logic [CNT_W-1:0]      ret_cycles,
   output logic                  busy,
   output logic                  done,
   output logic                  op_valid,
   output logic                  op_rd,
   output logic                  op_val,
   output logic [ADDR_W-1:0]     op_addr,
   output logic [ELEM_IDX_W-1:0] op_elem
);

   typedef enum logic [1:0] {S_IDLE, S_RUN, S_PAUSE, S_DRAIN} st_e;

   st_e                   state;
   logic [2:0]            alg_q;
   logic [ELEM_IDX_W-1:0] elem_idx;
   logic [1:0]            op_idx;
   logic [ADDR_W-1:0]     addr;
   logic [CNT_W-1:0]      cnt, ret_q;
   elem_t                 cur, nxt, first;
   logic [ADDR_W-1:0]     end_addr;
   logic                  last_op;

   always_comb begin
      cur      = alg_elem(alg_q, elem_idx);
      nxt      = alg_elem(alg_q, elem_idx + 3'd1);
      first    = alg_elem(alg, 3'd0);
      end_addr = cur.down ? '0 : '1;
      last_op  = (op_idx == cur.nops - 2'd1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= S_IDLE;
         done     <= 1'b0;
         alg_q    <= '0;
         elem_idx <= '0;
         op_idx   <= '0;
         addr     <= '0;
         cnt      <= '0;
         ret_q    <= '0;
      end else begin
         case (state)
            S_IDLE: if (start) begin
               alg_q    <= alg;
               ret_q    <= ret_cycles;
               elem_idx <= '0;
               op_idx   <= '0;
               addr     <= first.down ? '1 : '0;
               done     <= 1'b0;
               state    <= S_RUN;
            end
            S_RUN: begin
               if (!last_op) begin
                  op_idx <= op_idx + 2'd1;
               end else begin
                  op_idx <= '0;
                  if (addr != end_addr) begin
                     addr <= cur.down ? addr - 1'b1 : addr + 1'b1;
                  end else if (elem_idx == alg_last(alg_q)) begin
                     state <= S_DRAIN;
                  end else begin
                     elem_idx <= elem_idx + 3'd1;
                     addr     <= nxt.down ? '1 : '0;
                     if (nxt.pause) begin
                        cnt   <= ret_q;
                        state <= S_PAUSE;
                     end
                  end
               end
            end
            S_PAUSE: begin
               if (cnt == '0) state <= S_RUN;
               else cnt <= cnt - 1'b1;
            end
            default: begin
               state <= S_IDLE;
               done  <= 1'b1;
            end
         endcase
      end
   end

   assign busy     = (state != S_IDLE);
   assign op_valid = (state == S_RUN);
   assign op_rd    = cur.rd[op_idx];
   assign op_val   = cur.val[op_idx];
   assign op_addr  = addr;
   assign op_elem  = elem_idx;

endmodule

// File: rtl/mbist_cmp.sv
module mbist_cmp
   import mbist_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter int DATA_W    = 8,
   parameter bit KEEP_DATA = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clear,
   input  logic                  rd_issue,
   input  logic                  exp_val,
   input  logic [ADDR_W-1:0]     issue_addr,
   input  logic [ELEM_IDX_W-1:0] issue_elem,
   input  logic [DATA_W-1:0]     rdata,
   output logic                  fail,
   output logic [ADDR_W-1:0]     fail_addr,
   output logic [ELEM_IDX_W-1:0] fail_elem,
   output logic [DATA_W-1:0]     fail_data
);

   logic                  pend, exp_q;
   logic [ADDR_W-1:0]     addr_q;
   logic [ELEM_IDX_W-1:0] elem_q;
   logic                  hit;

   assign hit = pend && !fail && (rdata != {DATA_W{exp_q}});

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         pend      <= 1'b0;
         exp_q     <= 1'b0;
         addr_q    <= '0;
         elem_q    <= '0;
         fail      <= 1'b0;
         fail_addr <= '0;
         fail_elem <= '0;
      end else begin
         pend   <= rd_issue;
         exp_q  <= exp_val;
         addr_q <= issue_addr;
         elem_q <= issue_elem;
         if (hit) begin
            fail      <= 1'b1;
            fail_addr <= addr_q;
            fail_elem <= elem_q;
         end
      end
   end

   generate
      if (KEEP_DATA) begin : g_keep
         logic [DATA_W-1:0] data_q;
         always_ff @(posedge clk) begin
            if (!rst_n || clear) data_q <= '0;
            else if (hit)        data_q <= rdata;
         end
         assign fail_data = data_q;
      end else begin : g_drop
         assign fail_data = '0;
      end
   endgenerate

endmodule

// File: rtl/mbist_march_engine.sv
module mbist_march_engine
   import mbist_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter int DATA_W    = 8,
   parameter int CNT_W     = 16,
   parameter bit KEEP_DATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [2:0]        alg_sel,
   input  logic [CNT_W-1:0]  ret_cycles,
   output logic              busy,
   output logic              done,
   output logic              fail,
   output logic [ADDR_W-1:0] fail_addr,
   output logic [2:0]        fail_elem,
   output logic [DATA_W-1:0] fail_data,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_we,
   output logic              mem_re,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata
);

   generate
      if (ADDR_W < 1 || ADDR_W > 30) begin : g_bad_addr
         $error("ADDR_W out of range");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("DATA_W must be positive");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("CNT_W must be positive");
      end
   endgenerate

   logic                  op_valid, op_rd, op_val;
   logic [ADDR_W-1:0]     op_addr;
   logic [ELEM_IDX_W-1:0] op_elem;
   logic                  accept;

   assign accept = start && !busy;

   mbist_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .alg(alg_sel),
      .ret_cycles(ret_cycles), .busy(busy), .done(done),
      .op_valid(op_valid), .op_rd(op_rd), .op_val(op_val),
      .op_addr(op_addr), .op_elem(op_elem)
   );

   mbist_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEEP_DATA(KEEP_DATA)) u_cmp (
      .clk(clk), .rst_n(rst_n), .clear(accept),
      .rd_issue(op_valid && op_rd), .exp_val(op_val),
      .issue_addr(op_addr), .issue_elem(op_elem), .rdata(mem_rdata),
      .fail(fail), .fail_addr(fail_addr), .fail_elem(fail_elem),
      .fail_data(fail_data)
   );

   assign mem_addr  = op_addr;
   assign mem_we    = op_valid && !op_rd;
   assign mem_re    = op_valid && op_rd;
   assign mem_wdata = {DATA_W{op_val}};

endmodule

// File: rtl/mbist_march_sva.sv
module mbist_march_sva #(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic              done,
   input logic              fail,
   input logic [ADDR_W-1:0] fail_addr,
   input logic [2:0]        fail_elem,
   input logic [DATA_W-1:0] fail_data,
   input logic              mem_we,
   input logic              mem_re
);

   assert_single_op_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && mem_re));

   assert_start_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> busy);

   assert_read_drained_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_re |=> busy);

   assert_done_after_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(busy) && !busy);

   assert_fail_after_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fail) |-> $past(busy));

   assert_capture_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fail && (busy || !start)) |=> fail && $stable(fail_addr) && $stable(fail_elem)
                                     && $stable(fail_data));

endmodule

bind mbist_march_engine mbist_march_sva #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sva (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
   .fail(fail), .fail_addr(fail_addr), .fail_elem(fail_elem),
   .fail_data(fail_data), .mem_we(mem_we), .mem_re(mem_re)
);

// File: tb/tb_mbist_march_engine.sv
module tb_mbist_march_engine;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 4;
   localparam int DW = 8;
   localparam int N  = 1 << AW;
   localparam int CW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [2:0]    alg_sel = '0;
   logic [CW-1:0] ret_cycles = '0;
   logic          busy, done, fail;
   logic [AW-1:0] fail_addr, mem_addr;
   logic [2:0]    fail_elem;
   logic [DW-1:0] fail_data, mem_wdata;
   logic [DW-1:0] mem_rdata = '0;
   logic          mem_we, mem_re;

   int n_chk = 0;
   int n_bad = 0;

   // bench RAM with an optional stuck bit on one word
   logic [DW-1:0] ram [N];
   bit            f_en = 1'b0;
   int            f_addr = 0;
   int            f_bit = 0;
   bit            f_val = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mbist_march_engine #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .alg_sel(alg_sel),
      .ret_cycles(ret_cycles), .busy(busy), .done(done), .fail(fail),
      .fail_addr(fail_addr), .fail_elem(fail_elem), .fail_data(fail_data),
      .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   always @(posedge clk) begin
      if (mem_we) ram[mem_addr] <= mem_wdata;
      if (mem_re) begin
         mem_rdata <= ram[mem_addr];
         if (f_en && int'(mem_addr) == f_addr) mem_rdata[f_bit] <= f_val;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // element lists per R4: direction, pause flag, then op pairs
   function automatic string b_el(input int alg, input int e);
      case (alg)
         0: case (e) 0: return "U.w0"; 1: return "U.r0w1"; 2: return "U.r1"; default: return ""; endcase
         2: case (e) 0: return "U.w0"; 1: return "U.r0w1"; 2: return "D.r1w0r0"; default: return ""; endcase
         3: case (e) 0: return "U.w0"; 1: return "U.r0w1"; 2: return "D.r1w0"; 3: return "U.r0";
                     default: return ""; endcase
         4: case (e) 0: return "U.w0"; 1: return "U.r0w1"; 2: return "U.r1w0"; 3: return "D.r0w1";
                     4: return "D.r1w0"; 5: return "U.r0"; default: return ""; endcase
         5: case (e) 0: return "U.w0"; 1: return "U.r0w1r1"; 2: return "D.r1w0r0"; 3: return "U.r0";
                     default: return ""; endcase
         6: case (e) 0: return "U.w0"; 1: return "U.r0w1"; 2: return "U.r1w0"; 3: return "D.r0w1";
                     4: return "D.r1w0"; 5: return "UPr0w1"; 6: return "UPr1"; default: return ""; endcase
         default: case (e) 0: return "U.w0"; 1: return "U.r0w1"; 2: return "D.r1w0"; default: return ""; endcase
      endcase
   endfunction

   int  tick_n = 0;
   bit  mid_req = 1'b0;

   task automatic tick();
      @(negedge clk);
      tick_n++;
      if (tick_n == 1) start = 1'b0;
      if (mid_req && tick_n == 5) start = 1'b1;
      if (mid_req && tick_n == 6) start = 1'b0;
   endtask

   task automatic run_case(input int alg, input int ret, input bit fen, input int fa,
                           input int fb, input bit fv, input bit mid);
      string s;
      int    terr = 0;
      int    nops, a;
      bit    rd, v;
      int    exp_elem = -1;
      logic [DW-1:0] exp_data = '0;
      f_en = fen; f_addr = fa; f_bit = fb; f_val = fv;
      // first element holding a read whose background differs from the stuck value
      if (fen) begin
         for (int e = 0; e < 8 && exp_elem < 0; e++) begin
            s = b_el(alg, e);
            if (s.len() == 0) break;
            for (int i = 0; i < (s.len() - 2) / 2; i++)
               if (exp_elem < 0 && s[2+2*i] == "r" && ((s[3+2*i] == "1") != fv)) begin
                  exp_elem = e;
                  exp_data = {DW{s[3+2*i] == "1"}};
                  exp_data[fb] = fv;
               end
         end
      end
      @(negedge clk);
      alg_sel = alg[2:0];
      ret_cycles = CW'(ret);
      start = 1'b1;
      tick_n = 0;
      mid_req = mid;
      for (int e = 0; e < 8; e++) begin
         s = b_el(alg, e);
         if (s.len() == 0) break;
         if (s[1] == "P")
            for (int p = 0; p <= ret; p++) begin
               tick();
               if (mem_we || mem_re || !busy) terr++;
            end
         nops = (s.len() - 2) / 2;
         for (int k = 0; k < N; k++) begin
            a = (s[0] == "D") ? N - 1 - k : k;
            for (int i = 0; i < nops; i++) begin
               tick();
               if (tick_n == 1)
                  check(!fail && !done && busy, "R7", "cleared at start", {fail, done, busy}, 3'b001);
               rd = (s[2+2*i] == "r");
               v  = (s[3+2*i] == "1");
               if (!busy || mem_re != rd || mem_we != !rd || int'(mem_addr) != a) terr++;
               if (!rd && mem_wdata != {DW{v}}) terr++;
            end
         end
      end
      check(terr == 0, "R3", $sformatf("trace alg %0d", alg), terr, 0);
      tick();
      check(busy && !done && !mem_we && !mem_re, "R7", "drain cycle", {busy, done}, 2'b10);
      tick();
      check(!busy && done, "R7", "done after run", {busy, done}, 2'b01);
      if (!fen) begin
         check(!fail, "R9", $sformatf("clean alg %0d", alg), fail, 0);
      end else begin
         check(fail, "R6", "fail set", fail, 1);
         check(int'(fail_addr) == fa, "R6", "fail_addr", fail_addr, fa);
         check(int'(fail_elem) == exp_elem, "R6", "fail_elem", fail_elem, exp_elem);
         check(fail_data == exp_data, "R6", "fail_data", fail_data, exp_data);
      end
      mid_req = 1'b0;
      repeat (2) @(negedge clk);
      check(done && !busy, "R7", "done held", done, 1);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      int unsigned seed_init;
      seed_init = $urandom(32'd4711);
      for (int i = 0; i < N; i++) ram[i] = DW'($urandom);
      repeat (3) @(negedge clk);
      check(!busy && !done && !fail && !mem_we && !mem_re, "R1", "in reset",
            {busy, done, fail, mem_we, mem_re}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy && !done && !fail && !mem_we && !mem_re, "R1", "after reset",
            {busy, done, fail, mem_we, mem_re}, 0);
      // R4 R5 R9: every algorithm code on a clean memory
      for (int alg = 0; alg < 8; alg++) run_case(alg, 2, 1'b0, 0, 0, 1'b0, 1'b0);
      // R8: retention pauses of minimum and longer length
      run_case(6, 0, 1'b0, 0, 0, 1'b0, 1'b0);
      run_case(6, 37, 1'b0, 0, 0, 1'b0, 1'b0);
      // R6 R7: mismatch on the very last read, latched with done
      run_case(0, 0, 1'b1, N - 1, 0, 1'b0, 1'b0);
      // R6: stuck-at-1 seen in the first read element
      run_case(4, 1, 1'b1, 0, DW - 1, 1'b1, 1'b0);
      // R2: start pulsed mid-run
      run_case(5, 0, 1'b1, 7, 3, 1'b0, 1'b1);
      for (int r = 0; r < 24; r++)
         run_case(int'($urandom_range(0, 7)), int'($urandom_range(0, 20)),
                  1'($urandom_range(0, 1)), int'($urandom_range(0, N - 1)),
                  int'($urandom_range(0, DW - 1)), 1'($urandom_range(0, 1)),
                  1'($urandom_range(0, 1)));
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule